// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block owns the front end of a five-stage in-order pipeline: the program counter register, the fetch/decode instruction register, and the control half of the decode/execute register. Each cycle it looks at the instruction in the execute stage and asks two things: is that instruction a load, and does the register it loads into match either source register of the instruction now in decode? If both are true, the decode instruction cannot get its operand in time, even with forwarding. The block then freezes the program counter and the fetch/decode register for one cycle, and writes an all-zero control word into the decode/execute register. That zero word travels down the rest of the pipeline as a no-operation.

On the cycle after a stall, the load has moved to the memory stage. The instruction sitting in execute is now the bubble, so the hazard goes away on its own. The held instruction is then decoded a second time, and the loaded value reaches it through the memory/writeback forwarding path, which is outside this block. When no hazard is present, every register simply takes its next value. The program counter takes the sequential address supplied by the fetch logic, normally the current value plus 4.

A build parameter picks how to treat a load whose destination is register 0. By default such a load still stalls. This conservative choice is harmless and saves one comparator. The other setting filters that case out.

Top module: `loaduse_stall_ctrl`

## Requirements
- R1: The hold output is high in the same cycle when the execute-stage load flag is 1 and the execute destination index equals the first decode source index.
- R2: The hold output is high in the same cycle when the execute-stage load flag is 1 and the execute destination index equals the second decode source index.
- R3: The hold output is low when the execute-stage load flag is 0, even if the indices match.
- R4: The hold output is low when the execute-stage load flag is 1 but the destination index matches neither source index.
- R5: At a rising edge with hold high, the decode/execute control output becomes all zeros, whatever the decoded control input is.
- R6: At a rising edge with hold high, the program counter output keeps its value.
- R7: At a rising edge with hold high, the fetch/decode instruction output keeps its value, and the fetched word is ignored.
- R8: At a rising edge with hold low, the program counter takes the next-PC input, the fetch/decode output takes the fetched word, and the decode/execute control output takes the decoded control input.
- R9: At a rising edge with synchronous active-high reset asserted, the program counter, the fetch/decode output and the decode/execute control output all become zero.
- R10: With the default setting (SKIP_ZERO_DST = 0), a load whose destination index is 0 still raises hold when a source index is 0.
- R11: A load followed directly by a dependent instruction gives exactly one bubble: hold is high for one cycle and then low once the bubble occupies execute. The program counter is held for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ex_is_load | input | 1 | Memory-read flag of the instruction in execute |
| ex_dst_idx | input | IDX_W | Destination (rt) index of the instruction in execute |
| dec_src_a | input | IDX_W | First source (rs) index from the fetch/decode register |
| dec_src_b | input | IDX_W | Second source (rt) index from the fetch/decode register |
| pc_next | input | PC_W | Sequential next program counter value |
| fetch_word | input | INSN_W | Instruction word returned by fetch |
| dec_ctrl | input | CTRL_W | Control bits produced by the decoder |
| pc_q | output | PC_W | Program counter register |
| fd_word | output | INSN_W | Fetch/decode instruction register |
| de_ctrl | output | CTRL_W | Control part of the decode/execute register |
| hold | output | 1 | Combinational load-use hazard indication |

## Verification
The single-bubble property assumes a consistent environment. The execute-stage load flag and destination index must be what the surrounding pipeline derives from this block's own decode/execute output, so a cycle after a hold always presents the bubble, with its load flag at 0, to the comparator. The stimulus table keeps to this rule: every row that follows a hold row drives the load flag low. Between holds, the table drives independent loads and non-loads with arbitrary matching indices. This exercises both comparators, the register-0 case and the no-match case, without ever giving two holds in a row.

// File: rtl/lu_pkg.sv
package lu_pkg;
   // Default geometry for a 32-bit, 32-register in-order core
   localparam int unsigned LU_PC_W   = 32;
   localparam int unsigned LU_INSN_W = 32;
   localparam int unsigned LU_IDX_W  = 5;
   localparam int unsigned LU_CTRL_W = 9;

   // Index equality helper shared by the comparators
   function automatic logic idx_eq(input logic [LU_IDX_W-1:0] a,
                                   input logic [LU_IDX_W-1:0] b);
      return (a == b);
   endfunction
endpackage

// File: rtl/lu_hazard_cmp.sv
module lu_hazard_cmp #(
   parameter int unsigned IDX_W     = 5,
   parameter bit          SKIP_ZERO = 1'b0
) (
   input  logic             is_load,
   input  logic [IDX_W-1:0] dst_idx,
   input  logic [IDX_W-1:0] src_a,
   input  logic [IDX_W-1:0] src_b,
   output logic             hit
);
   logic match_a;
   logic match_b;
   logic dst_ok;

   assign match_a = (dst_idx == src_a);
   assign match_b = (dst_idx == src_b);

   generate
      if (SKIP_ZERO) begin : g_filter_zero
         // Register 0 can never carry a real dependence
         assign dst_ok = |dst_idx;
      end else begin : g_conservative
         assign dst_ok = 1'b1;
      end
   endgenerate

   assign hit = is_load & dst_ok & (match_a | match_b);
endmodule

// File: rtl/lu_hold_reg.sv
module lu_hold_reg #(
   parameter int unsigned W       = 32,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         freeze,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RST_VAL;
      end else if (!freeze) begin
         q <= d;
      end
   end
endmodule

// File: rtl/lu_bubble_reg.sv
module lu_bubble_reg #(
   parameter int unsigned W = 9
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         squash,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] d_gated;

   // All-zero control word is the no-operation marker downstream
   assign d_gated = squash ? '0 : d;

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         q <= d_gated;
      end
   end
endmodule

// File: rtl/loaduse_stall_ctrl.sv
module loaduse_stall_ctrl
   import lu_pkg::*;
#(
   parameter int unsigned PC_W          = LU_PC_W,
   parameter int unsigned INSN_W        = LU_INSN_W,
   parameter int unsigned IDX_W         = LU_IDX_W,
   parameter int unsigned CTRL_W        = LU_CTRL_W,
   parameter bit          SKIP_ZERO_DST = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ex_is_load,
   input  logic [IDX_W-1:0]  ex_dst_idx,
   input  logic [IDX_W-1:0]  dec_src_a,
   input  logic [IDX_W-1:0]  dec_src_b,
   input  logic [PC_W-1:0]   pc_next,
   input  logic [INSN_W-1:0] fetch_word,
   input  logic [CTRL_W-1:0] dec_ctrl,
   output logic [PC_W-1:0]   pc_q,
   output logic [INSN_W-1:0] fd_word,
   output logic [CTRL_W-1:0] de_ctrl,
   output logic              hold
);
   localparam logic [PC_W-1:0]   PC_RST   = '0;
   localparam logic [INSN_W-1:0] NOP_WORD = '0;

   // Elaboration-time parameter sanity
   generate
      if (PC_W < 2) begin : g_bad_pc_w
         $error("loaduse_stall_ctrl: PC_W must be at least 2");
      end
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx_w
         $error("loaduse_stall_ctrl: IDX_W out of range 1..8");
      end
      if (CTRL_W < 1) begin : g_bad_ctrl_w
         $error("loaduse_stall_ctrl: CTRL_W must be at least 1");
      end
      if (INSN_W < 3 * IDX_W) begin : g_bad_insn_w
         $error("loaduse_stall_ctrl: INSN_W too narrow for register fields");
      end
   endgenerate

   logic hazard;

   lu_hazard_cmp #(
      .IDX_W     (IDX_W),
      .SKIP_ZERO (SKIP_ZERO_DST)
   ) u_cmp (
      .is_load (ex_is_load),
      .dst_idx (ex_dst_idx),
      .src_a   (dec_src_a),
      .src_b   (dec_src_b),
      .hit     (hazard)
   );

   lu_hold_reg #(
      .W       (PC_W),
      .RST_VAL (PC_RST)
   ) u_pc (
      .clk    (clk),
      .rst    (rst),
      .freeze (hazard),
      .d      (pc_next),
      .q      (pc_q)
   );

   lu_hold_reg #(
      .W       (INSN_W),
      .RST_VAL (NOP_WORD)
   ) u_fd (
      .clk    (clk),
      .rst    (rst),
      .freeze (hazard),
      .d      (fetch_word),
      .q      (fd_word)
   );

   lu_bubble_reg #(
      .W (CTRL_W)
   ) u_de (
      .clk    (clk),
      .rst    (rst),
      .squash (hazard),
      .d      (dec_ctrl),
      .q      (de_ctrl)
   );

   assign hold = hazard;
endmodule

// File: rtl/lu_stall_chk.sv
module lu_stall_chk #(
   parameter int unsigned PC_W          = 32,
   parameter int unsigned INSN_W        = 32,
   parameter int unsigned IDX_W         = 5,
   parameter int unsigned CTRL_W        = 9,
   parameter bit          SKIP_ZERO_DST = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              ex_is_load,
   input logic [IDX_W-1:0]  ex_dst_idx,
   input logic [IDX_W-1:0]  dec_src_a,
   input logic [IDX_W-1:0]  dec_src_b,
   input logic [PC_W-1:0]   pc_next,
   input logic [INSN_W-1:0] fetch_word,
   input logic [CTRL_W-1:0] dec_ctrl,
   input logic [PC_W-1:0]   pc_q,
   input logic [INSN_W-1:0] fd_word,
   input logic [CTRL_W-1:0] de_ctrl,
   input logic              hold
);
   // R1
   src_a_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (ex_is_load && ex_dst_idx == dec_src_a && (ex_dst_idx != '0 || !SKIP_ZERO_DST)) |-> hold);

   // R2
   src_b_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (ex_is_load && ex_dst_idx == dec_src_b && (ex_dst_idx != '0 || !SKIP_ZERO_DST)) |-> hold);

   // R3
   non_load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !ex_is_load |-> !hold);

   // R4
   no_match_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (ex_dst_idx != dec_src_a && ex_dst_idx != dec_src_b) |-> !hold);

   // R5
   bubble_zero_chk: assert property (@(posedge clk) disable iff (rst)
      hold |=> (de_ctrl == '0));

   // R6
   pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      hold |=> (pc_q == $past(pc_q)));

   // R7
   fd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      hold |=> (fd_word == $past(fd_word)));

   // R8
   advance_chk: assert property (@(posedge clk) disable iff (rst)
      !hold |=> (pc_q == $past(pc_next) && fd_word == $past(fetch_word)
                 && de_ctrl == $past(dec_ctrl)));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (pc_q == '0 && fd_word == '0 && de_ctrl == '0));

   // R10
   zero_dst_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (!SKIP_ZERO_DST && ex_is_load && ex_dst_idx == '0 && dec_src_a == '0) |-> hold);

   // R11
   single_bubble_chk: assert property (@(posedge clk) disable iff (rst)
      hold |=> !hold);
endmodule

bind loaduse_stall_ctrl lu_stall_chk #(
   .PC_W          (PC_W),
   .INSN_W        (INSN_W),
   .IDX_W         (IDX_W),
   .CTRL_W        (CTRL_W),
   .SKIP_ZERO_DST (SKIP_ZERO_DST)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ex_is_load (ex_is_load),
   .ex_dst_idx (ex_dst_idx),
   .dec_src_a  (dec_src_a),
   .dec_src_b  (dec_src_b),
   .pc_next    (pc_next),
   .fetch_word (fetch_word),
   .dec_ctrl   (dec_ctrl),
   .pc_q       (pc_q),
   .fd_word    (fd_word),
   .de_ctrl    (de_ctrl),
   .hold       (hold)
);

// File: tb/loaduse_stall_ctrl_test.sv
module loaduse_stall_ctrl_test;
   localparam int unsigned PW = 32;
   localparam int unsigned IW = 32;
   localparam int unsigned XW = 5;
   localparam int unsigned CW = 9;

   typedef struct packed {
      logic          ld;
      logic [XW-1:0] dst;
      logic [XW-1:0] sa;
      logic [XW-1:0] sb;
      logic          exp_hold;
      logic [23:0]   tag;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 5'd0,  5'd1,  5'd2,  1'b0, "R8 "},
      '{1'b0, 5'd5,  5'd5,  5'd6,  1'b0, "R3 "},
      '{1'b1, 5'd8,  5'd8,  5'd9,  1'b1, "R1 "},
      '{1'b0, 5'd0,  5'd8,  5'd9,  1'b0, "R11"},
      '{1'b1, 5'd7,  5'd3,  5'd7,  1'b1, "R2 "},
      '{1'b0, 5'd0,  5'd3,  5'd7,  1'b0, "R11"},
      '{1'b1, 5'd10, 5'd11, 5'd12, 1'b0, "R4 "},
      '{1'b1, 5'd0,  5'd0,  5'd4,  1'b1, "R10"},
      '{1'b0, 5'd0,  5'd0,  5'd0,  1'b0, "R3 "},
      '{1'b1, 5'd31, 5'd31, 5'd31, 1'b1, "R1 "},
      '{1'b0, 5'd31, 5'd31, 5'd31, 1'b0, "R3 "},
      '{1'b1, 5'd4,  5'd9,  5'd2,  1'b0, "R4 "}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ex_is_load = 1'b0;
   logic [XW-1:0] ex_dst_idx = '0;
   logic [XW-1:0] dec_src_a = '0;
   logic [XW-1:0] dec_src_b = '0;
   logic [PW-1:0] pc_next = '0;
   logic [IW-1:0] fetch_word = '0;
   logic [CW-1:0] dec_ctrl = '0;
   logic [PW-1:0] pc_q;
   logic [IW-1:0] fd_word;
   logic [CW-1:0] de_ctrl;
   logic          hold;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   loaduse_stall_ctrl uut (
      .clk        (clk),
      .rst        (rst),
      .ex_is_load (ex_is_load),
      .ex_dst_idx (ex_dst_idx),
      .dec_src_a  (dec_src_a),
      .dec_src_b  (dec_src_b),
      .pc_next    (pc_next),
      .fetch_word (fetch_word),
      .dec_ctrl   (dec_ctrl),
      .pc_q       (pc_q),
      .fd_word    (fd_word),
      .de_ctrl    (de_ctrl),
      .hold       (hold)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [PW-1:0] e_pc;
      logic [IW-1:0] e_fd;
      logic [CW-1:0] e_ctrl;

      // R9: reset with busy inputs
      pc_next    = 32'h0000_0040;
      fetch_word = 32'hDEAD_BEEF;
      dec_ctrl   = 9'h1FF;
      @(posedge clk);
      @(posedge clk);
      #1;
      check(pc_q == '0, "R9", "pc after reset", pc_q, 0);
      check(fd_word == '0, "R9", "fd after reset", fd_word, 0);
      check(de_ctrl == '0, "R9", "ctrl after reset", de_ctrl, 0);
      @(negedge clk);
      rst = 1'b0;
      e_pc = '0; e_fd = '0; e_ctrl = '0;

      for (int i = 0; i < NV; i++) begin
         string t;
         t = (VECS[i].tag[7:0] == " ") ? string'(VECS[i].tag[23:8]) : string'(VECS[i].tag);
         ex_is_load = VECS[i].ld;
         ex_dst_idx = VECS[i].dst;
         dec_src_a  = VECS[i].sa;
         dec_src_b  = VECS[i].sb;
         pc_next    = 32'h0000_0100 + 32'(4 * i);
         fetch_word = 32'hA500_0000 ^ 32'(i * 32'h0001_0111);
         dec_ctrl   = 9'h1A5 ^ 9'(i + 1);
         #1;
         check(hold == VECS[i].exp_hold, t, "hold", 64'(hold), 64'(VECS[i].exp_hold));
         if (!VECS[i].exp_hold) begin
            e_pc = pc_next; e_fd = fetch_word; e_ctrl = dec_ctrl;
         end else begin
            e_ctrl = '0;
         end
         @(posedge clk);
         #1;
         check(pc_q == e_pc, VECS[i].exp_hold ? "R6" : "R8", "pc", pc_q, e_pc);
         check(fd_word == e_fd, VECS[i].exp_hold ? "R7" : "R8", "fd", fd_word, e_fd);
         check(de_ctrl == e_ctrl, VECS[i].exp_hold ? "R5" : "R8", "ctrl", de_ctrl, e_ctrl);
         @(negedge clk);
      end

      // R11: load then dependent use, PC held exactly one cycle
      ex_is_load = 1'b1; ex_dst_idx = 5'd12; dec_src_a = 5'd1; dec_src_b = 5'd12;
      pc_next = 32'h0000_0300; fetch_word = 32'h1111_2222; dec_ctrl = 9'h0C3;
      #1;
      check(hold == 1'b1, "R11", "hold on dependent", 64'(hold), 1);
      e_pc = pc_q;
      @(posedge clk);
      @(negedge clk);
      check(pc_q == e_pc, "R11", "pc held", pc_q, e_pc);
      check(de_ctrl == '0, "R11", "bubble", de_ctrl, 0);
      ex_is_load = 1'b0; ex_dst_idx = 5'd0;
      #1;
      check(hold == 1'b0, "R11", "hold released", 64'(hold), 0);
      @(posedge clk);
      #1;
      check(pc_q == 32'h0000_0300, "R11", "pc advances", pc_q, 32'h300);
      check(fd_word == 32'h1111_2222, "R11", "fd advances", fd_word, 32'h1111_2222);

      // R9: reset in mid-run during a hazard
      @(negedge clk);
      ex_is_load = 1'b1; ex_dst_idx = 5'd3; dec_src_a = 5'd3;
      rst = 1'b1;
      @(posedge clk);
      #1;
      check(pc_q == '0, "R9", "pc mid-run reset", pc_q, 0);
      check(fd_word == '0, "R9", "fd mid-run reset", fd_word, 0);
      check(de_ctrl == '0, "R9", "ctrl mid-run reset", de_ctrl, 0);
      @(negedge clk);
      rst = 1'b0;
      ex_is_load = 1'b0;

      finish_run();
   end
endmodule